// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves 8-bit frames over one shared data line while it drives the shift clock itself on a second line. A frame goes out least significant bit first when a byte is written to the port. A frame comes in when the receive enable is set and the previous received byte has been acknowledged. The direction of the shared data line follows the active transfer: the block drives the line only while it transmits and releases it at all other times.

Outgoing bytes enter through a valid/ready write channel. A write beat is taken on any clock where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while no frame is in progress, so a producer that sees it low must hold `wr_valid` and `wr_data` steady until the beat is taken. Back-pressure therefore lasts for at most one frame. The received byte sits in its own buffer on `rd_data`. That buffer is separate from the transmit register, so a write never disturbs it.

The bit rate is the system clock divided by 12, or divided by 4 when the rate-select input is high. Within each bit period the shift clock is low for the first half and high for the second. Outgoing data changes on the falling edge. Incoming data is captured in the last system clock before the rising edge. Between frames the shift clock idles high. Two sticky flags report completed frames, and software clears them with one-cycle clear pulses.

Top module: `ssp_port`

## Requirements
- R1: While reset is held, and right after it, `sclk` is 1, `sd_oe` is 0, `sd_out` is 1, `wr_ready` is 1, both done flags are 0 and `rd_data` is 0.
- R2: `wr_ready` is 1 exactly when no frame is in progress. A beat with `wr_valid` and `wr_ready` both high starts a transmit frame in the next cycle, and a beat that is not taken has no effect.
- R3: A transmit frame carries the 8 bits of the written byte, bit 0 first. Bit k is on `sd_out` for the whole k-th bit period. `sd_oe` is 1 for exactly the frame's cycles and 0 in every other cycle, including during reception. When `sd_oe` is 0, `sd_out` reads 1.
- R4: A frame's bit period is 12 system clocks when `fast_rate` is 0 at the start of the frame, and 4 when it is 1. A change of `fast_rate` during a frame has no effect on that frame. In each bit period `sclk` is 0 for the first half and 1 for the second half, and `sclk` is 1 when idle.
- R5: In a receive frame, bit k of the received byte is the value of `sd_in` in the last system clock cycle of the low half of the k-th bit period. `sd_in` in any other cycle is ignored.
- R6: `rd_data` changes only in the cycle after a receive frame ends, when it takes the received byte. Transmit writes leave it unchanged.
- R7: From idle, a receive frame starts in the next cycle when `rx_en` is 1, `rx_done` is 0 and `wr_valid` is 0. A pending write takes precedence over reception, and no reception starts while `rx_done` is 1.
- R8: `tx_done` (or `rx_done`) becomes 1 in the cycle after the last bit period of a transmit (or receive) frame. The flag stays 1 until a cycle with `tx_done_clr` (or `rx_done_clr`) high, and a completion in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_rate | input | 1 | 1 selects clk/4 bit rate, 0 selects clk/12; sampled at frame start |
| wr_valid | input | 1 | Transmit byte offered |
| wr_ready | output | 1 | Port idle, write beat can be taken |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Receive buffer |
| rx_en | input | 1 | Allows a reception to start |
| tx_done | output | 1 | Sticky transmit-complete flag |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done | output | 1 | Sticky receive-complete flag |
| rx_done_clr | input | 1 | Clears rx_done |
| sclk | output | 1 | Shift clock, driven in both directions, idles high |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_in | input | 1 | Data line input value |

## Verification
Transmission is tried with bytes that have alternating and grouped bit patterns at both rates, and the rate select is toggled in the middle of a frame. This separates a latched rate from one that is read live and shows whether the bit order is reversed. Reception is tried once with data held for the whole bit and once with the correct value present only in the cycle before the rising clock edge and the inverted value elsewhere. Only a design that samples in that exact cycle captures the second pattern. A write and a receive enable raised in the same cycle, a write held during reception, and a receive enable held while the receive flag is set test the start priority, the back-pressure and the blocking rule.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  typedef enum logic [1:0] {
    SSP_IDLE = 2'd0,
    SSP_TX   = 2'd1,
    SSP_RX   = 2'd2
  } ssp_dir_e;
endpackage

// File: rtl/ssp_bitclk.sv
`timescale 1ns/1ps
// Bit timing: phase and bit counters, shift clock, strobes.
module ssp_bitclk #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int BITS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  output logic busy,
  output logic sclk,
  output logic sample_stb,
  output logic bit_end,
  output logic last_stb
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CW   = $clog2(MAXD);
  localparam int BW   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] S_END = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] F_END = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] S_HI  = CW'(SLOW_DIV / 2);
  localparam logic [CW-1:0] F_HI  = CW'(FAST_DIV / 2);
  localparam logic [BW-1:0] B_LAST = BW'(BITS - 1);

  logic [CW-1:0] ph;
  logic [BW-1:0] bitn;
  logic          fast_q;
  logic [CW-1:0] ph_end, ph_hi;

  assign ph_end = fast_q ? F_END : S_END;
  assign ph_hi  = fast_q ? F_HI  : S_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      fast_q <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      ph     <= '0;
      bitn   <= '0;
      fast_q <= fast;
    end else if (busy) begin
      if (ph == ph_end) begin
        ph <= '0;
        if (bitn == B_LAST) busy <= 1'b0;
        else                bitn <= bitn + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign sclk       = !busy || (ph >= ph_hi);
  assign sample_stb = busy && (ph == ph_hi - 1'b1);
  assign bit_end    = busy && (ph == ph_end);
  assign last_stb   = bit_end && (bitn == B_LAST);
endmodule

// File: rtl/ssp_shreg.sv
`timescale 1ns/1ps
// Right-shifting frame register, serial input enters at the top.
module ssp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/ssp_port.sv
`timescale 1ns/1ps
module ssp_port #(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_rate,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_en,
  output logic              tx_done,
  input  logic              tx_done_clr,
  output logic              rx_done,
  input  logic              rx_done_clr,
  output logic              sclk,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic              sd_in
);
  import ssp_pkg::*;

  ssp_dir_e          dir;
  logic              wr_fire, rx_go, start;
  logic              sample_stb, bit_end, last_stb, clk_busy;
  logic              sh_en;
  logic [DATA_W-1:0] shq;

  assign wr_ready = (dir == SSP_IDLE);
  assign wr_fire  = wr_valid && wr_ready;
  assign rx_go    = wr_ready && !wr_valid && rx_en && !rx_done;
  assign start    = wr_fire || rx_go;

  ssp_bitclk #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .BITS(DATA_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .fast(fast_rate),
    .busy(clk_busy), .sclk(sclk), .sample_stb(sample_stb),
    .bit_end(bit_end), .last_stb(last_stb)
  );

  always_comb begin
    unique case (dir)
      SSP_TX:  sh_en = bit_end && !last_stb;
      SSP_RX:  sh_en = sample_stb;
      default: sh_en = 1'b0;
    endcase
  end

  ssp_shreg #(.W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(start),
    .load_val(wr_fire ? wr_data : '0),
    .shift(sh_en), .ser_in(sd_in), .q(shq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir     <= SSP_IDLE;
      rd_data <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (start)                      dir <= wr_fire ? SSP_TX : SSP_RX;
      else if (last_stb && clk_busy)  dir <= SSP_IDLE;

      if (dir == SSP_TX && last_stb)  tx_done <= 1'b1;
      else if (tx_done_clr)           tx_done <= 1'b0;

      if (dir == SSP_RX && last_stb) begin
        rx_done <= 1'b1;
        rd_data <= shq;
      end else if (rx_done_clr) begin
        rx_done <= 1'b0;
      end
    end
  end

  assign sd_oe  = (dir == SSP_TX);
  assign sd_out = sd_oe ? shq[0] : 1'b1;
endmodule

// File: rtl/ssp_port_chk.sv
`timescale 1ns/1ps
module ssp_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_en,
  input logic              tx_done,
  input logic              tx_done_clr,
  input logic              rx_done,
  input logic              rx_done_clr,
  input logic              sclk,
  input logic              sd_oe,
  input logic              dir_busy,
  input logic              bclk_busy
);
  p_oe_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> !wr_ready);

  p_sclk_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> sclk);

  p_accept_starts_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> sd_oe);

  p_counters_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_busy == bclk_busy);

  p_txdone_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done);

  p_rxdone_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> rx_done);

  p_rdbuf_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(rx_done));

  p_no_rx_while_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr && wr_ready && !wr_valid && rx_en) |=> wr_ready);
endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_data(rd_data), .rx_en(rx_en), .tx_done(tx_done),
  .tx_done_clr(tx_done_clr), .rx_done(rx_done), .rx_done_clr(rx_done_clr),
  .sclk(sclk), .sd_oe(sd_oe), .dir_busy(dir != ssp_pkg::SSP_IDLE),
  .bclk_busy(u_clk.busy)
);

// File: tb/ssp_port_test.sv
`timescale 1ns/1ps
module ssp_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_rate = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_en = 1'b0;
  logic       tx_done, rx_done;
  logic       tx_done_clr = 1'b0, rx_done_clr = 1'b0;
  logic       sclk, sd_out, sd_oe;
  logic       sd_in = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int         m_mode = 0, m_cnt = 0, m_per = 12;
  logic [7:0] m_tx = 0, m_acc = 0, m_buf = 0;
  bit         m_txd = 0, m_rxd = 0;
  logic [7:0] pat = 8'h00;
  bit         narrow = 0;

  always #5 clk = ~clk;

  ssp_port uut (
    .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_data(rd_data), .rx_en(rx_en),
    .tx_done(tx_done), .tx_done_clr(tx_done_clr), .rx_done(rx_done),
    .rx_done_clr(rx_done_clr), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe),
    .sd_in(sd_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // model update on the same edge the design uses
  always @(posedge clk) begin
    int fin;
    fin = 0;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_per = 12; m_txd = 0; m_rxd = 0;
      m_buf = 0; m_acc = 0;
    end else begin
      if (m_mode == 0) begin
        if (wr_valid) begin
          m_mode = 1; m_cnt = 0; m_per = fast_rate ? 4 : 12; m_tx = wr_data;
        end else if (rx_en && !m_rxd) begin
          m_mode = 2; m_cnt = 0; m_per = fast_rate ? 4 : 12; m_acc = 0;
        end
      end else begin
        if (m_mode == 2 && (m_cnt % m_per) == m_per / 2 - 1)
          m_acc[m_cnt / m_per] = sd_in;
        m_cnt++;
        if (m_cnt == 8 * m_per) begin
          fin = m_mode; m_mode = 0; m_cnt = 0;
        end
      end
      if (tx_done_clr) m_txd = 0;
      if (rx_done_clr) m_rxd = 0;
      if (fin == 1) m_txd = 1;
      if (fin == 2) begin m_rxd = 1; m_buf = m_acc; end
    end
  end

  // compare every cycle away from the edge, then drive the external device
  always @(negedge clk) begin
    if (rst_n) begin
      int ph, bt;
      bit e_sclk;
      ph = m_cnt % m_per;
      bt = m_cnt / m_per;
      e_sclk = (m_mode == 0) ? 1'b1 : (ph >= m_per / 2);
      check(sclk == e_sclk, "R4 R7 sclk", sclk, e_sclk);
      check(sd_oe == (m_mode == 1), "R3 sd_oe", sd_oe, m_mode == 1);
      check(sd_out == ((m_mode == 1) ? m_tx[bt] : 1'b1), "R3 sd_out", sd_out,
            (m_mode == 1) ? m_tx[bt] : 1'b1);
      check(wr_ready == (m_mode == 0), "R2 wr_ready", wr_ready, m_mode == 0);
      check(tx_done == m_txd, "R8 tx_done", tx_done, m_txd);
      check(rx_done == m_rxd, "R8 rx_done", rx_done, m_rxd);
      check(rd_data == m_buf, "R5 R6 rd_data", rd_data, m_buf);
    end
    if (m_mode == 2) begin
      int ph, bt;
      ph = m_cnt % m_per;
      bt = m_cnt / m_per;
      if (narrow) sd_in = (ph == m_per / 2 - 1) ? pat[bt] : ~pat[bt];
      else        sd_in = pat[bt];
    end else begin
      sd_in = 1'b1;
    end
  end

  task automatic put_byte(input logic [7:0] d, input bit f);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; fast_rate = f;
    forever begin
      @(posedge clk);
      if (wr_ready) break;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_clr(input bit t, input bit r);
    @(negedge clk);
    tx_done_clr = t; rx_done_clr = r;
    @(negedge clk);
    tx_done_clr = 1'b0; rx_done_clr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(sd_oe == 1'b0, "R1 sd_oe", sd_oe, 0);
    check(sd_out == 1'b1, "R1 sd_out", sd_out, 1);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    check(tx_done == 1'b0 && rx_done == 1'b0, "R1 flags", {tx_done, rx_done}, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    idle_cycles(3);

    // R3 R4: slow transmit
    put_byte(8'hA5, 1'b0);
    idle_cycles(100);
    check(tx_done == 1'b1, "R8 tx_done after slow frame", tx_done, 1);
    pulse_clr(1'b1, 1'b0);

    // R4: fast transmit, rate select toggled mid-frame
    put_byte(8'h3C, 1'b1);
    idle_cycles(10);
    fast_rate = 1'b0;
    idle_cycles(30);
    pulse_clr(1'b1, 1'b0);

    // R5: slow receive, data held for the whole bit
    pat = 8'h96; fast_rate = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    idle_cycles(140);   // R7: stays idle while rx_done is set
    check(rd_data == 8'h96, "R5 slow receive", rd_data, 8'h96);
    rx_en = 1'b0;
    pulse_clr(1'b0, 1'b1);

    // R5: fast receive, correct value only in the sampling cycle
    pat = 8'h5A; narrow = 1; fast_rate = 1'b1;
    @(negedge clk); rx_en = 1'b1;
    idle_cycles(40);
    check(rd_data == 8'h5A, "R5 narrow receive", rd_data, 8'h5A);
    rx_en = 1'b0; narrow = 0;
    pulse_clr(1'b0, 1'b1);

    // R7: write and receive enable together, write wins; R2: held write
    pat = 8'h0F; fast_rate = 1'b1;
    @(negedge clk);
    rx_en = 1'b1; wr_valid = 1'b1; wr_data = 8'hC3;
    @(negedge clk);
    wr_valid = 1'b0;
    idle_cycles(34);    // reception has started after the transmit
    put_byte(8'h81, 1'b0);  // held through the reception
    rx_en = 1'b0;
    idle_cycles(100);
    check(rd_data == 8'h0F, "R6 buffer after writes", rd_data, 8'h0F);
    pulse_clr(1'b1, 1'b1);
    idle_cycles(5);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule